// File: doc/BRIEF.md
# Serial Slave Front End with Pause Control

This block is the serial-facing edge of a memory-style peripheral. It oversamples the four serial pins (clock, active-low select, data in, active-low pause) on the system clock and works in SPI mode 0: it samples the input line on each rising serial-clock edge and moves the output line on each falling edge. Data moves most significant bit first. The first byte after select is asserted is taken as a command code. That code is checked against a parameter list of permitted values and reported on its own strobe.

Every later byte is handed to the core on a parallel strobe together with its position in the transfer. The core supplies the next reply byte on a parallel input, and the block captures it at each byte boundary. An unlisted command makes the block ignore the rest of the transfer. A low pause input, taken while the serial clock is low, freezes the transfer in place until the pause is released.

Top module: `spi_hold_frontend`

## Requirements
- R1: Bits move most significant first in both directions. The input line is taken on the serial-clock rising edge, and the output line changes only on the serial-clock falling edge.
- R2: The first byte after the select falls is presented on `opcode_o` with a one-cycle `opcode_valid_o`, in the same cycle as its `rx_valid_o`. `opcode_legal_o` is 1 exactly when that byte equals one of the `NUM_LEGAL` 8-bit entries of `LEGAL_CODES` (entry k in bits [8k+7:8k]).
- R3: After an unlisted command byte, no further `rx_valid_o` pulses occur and `so_oe_o` stays 0 until the select falls again.
- R4: While the select is high, serial-clock edges and the input line have no effect: there is no strobe and `so_oe_o` is 0.
- R5: A low pause input, taken while the serial clock is low, drives `so_oe_o` to 0 and makes the block ignore clock edges and the input line. Setting the pause input high while the serial clock is low resumes the transfer at the same bit, both inward and outward.
- R6: Every eighth accepted bit produces a one-cycle `rx_valid_o` with the assembled byte on `rx_byte_o` and its position on `rx_idx_o`. The position is 0 for the command byte and increases by 1 for each later byte.
- R7: At the falling edge that ends each byte, `tx_byte_i` is captured, and its bits appear on `so_o` during the next byte. During the command byte, `so_o` reads 0. `so_oe_o` is 1 whenever the block is selected, not paused and not locked.
- R8: A falling select clears the bit count, the byte position and the lock. A transfer cut off in the middle of a byte leaves no trace in the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, well above the serial clock rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the master |
| cs_ni | input | 1 | Select, active low |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Pause request, active low |
| so_o | output | 1 | Serial data out; meaningful only when so_oe_o is 1 |
| so_oe_o | output | 1 | Output enable for the pad tri-state driver |
| opcode_o | output | 8 | Command byte of the current transfer |
| opcode_valid_o | output | 1 | One-cycle strobe when a command byte completes |
| opcode_legal_o | output | 1 | Command byte is in the permitted list |
| rx_byte_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe per received byte |
| rx_idx_o | output | IDX_W | Position of rx_byte_o in the transfer; saturates at its maximum |
| tx_byte_i | input | 8 | Reply byte, captured at each byte boundary |

## Verification
The bench builds the block with a three-stage synchronizer and a permitted list of three codes. The longer synchronizer widens the gap between a pin change and its effect, so the check that reply bits arrive on time is taken with the extra latency in the path. The short list sets the matching logic to a size other than its default, and random command bytes fall outside the list often enough to reach the lock path many times. Random pause points, including pauses inside the command byte and at byte boundaries, test the freeze at every bit position.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_W  = $clog2(BYTE_W);
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  if (STAGES <= 1) begin : g_single
    logic [WIDTH-1:0] q_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q <= RST_VAL;
      else         q_q <= d_i;
    end
    assign q_o = q_q;
  end else begin : g_chain
    logic [STAGES-1:0][WIDTH-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
    assign q_o = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spi_fe_opcheck.sv
module spi_fe_opcheck
  import spi_fe_pkg::*;
#(
  parameter int                     NUM   = 4,
  parameter logic [NUM*BYTE_W-1:0]  CODES = '0
) (
  input  byte_t code_i,
  output logic  legal_o
);
  logic [NUM-1:0] hit;
  for (genvar k = 0; k < NUM; k++) begin : g_cmp
    assign hit[k] = (code_i == CODES[k*BYTE_W +: BYTE_W]);
  end
  assign legal_o = |hit;
endmodule

// File: rtl/spi_fe_txshift.sv
module spi_fe_txshift
  import spi_fe_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  load_i,
  input  logic  shift_i,
  input  byte_t din_i,
  output logic  msb_o
);
  byte_t sh_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (clr_i)   sh_q <= '0;
    else if (load_i)  sh_q <= din_i;
    else if (shift_i) sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
  end
  assign msb_o = sh_q[BYTE_W-1];
endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend
  import spi_fe_pkg::*;
#(
  parameter int                          SYNC_STAGES = 2,
  parameter int                          IDX_W       = 4,
  parameter int                          NUM_LEGAL   = 4,
  parameter logic [NUM_LEGAL*BYTE_W-1:0] LEGAL_CODES = {8'h06, 8'h05, 8'h02, 8'h03}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             cs_ni,
  input  logic             si_i,
  input  logic             hold_ni,
  output logic             so_o,
  output logic             so_oe_o,
  output byte_t            opcode_o,
  output logic             opcode_valid_o,
  output logic             opcode_legal_o,
  output byte_t            rx_byte_o,
  output logic             rx_valid_o,
  output logic [IDX_W-1:0] rx_idx_o,
  input  byte_t            tx_byte_i
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  // pin order: sck, cs_n, si, hold_n
  logic [3:0] pins_s;
  spi_fe_sync #(
    .WIDTH  (4),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b0101)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sck_i, cs_ni, si_i, hold_ni}),
    .q_o    (pins_s)
  );

  logic sck_s, cs_q, si_s, hold_s;
  assign sck_s  = pins_s[3];
  assign cs_q   = pins_s[2];
  assign si_s   = pins_s[1];
  assign hold_s = pins_s[0];

  logic sck_d, cs_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_q;
    end
  end

  logic cs_fall, sck_rise, sck_fall;
  assign cs_fall  = cs_d & ~cs_q;
  assign sck_rise = ~sck_d & sck_s;
  assign sck_fall = sck_d & ~sck_s;

  // pause state only moves while the serial clock is low
  logic held_q, locked_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     held_q <= 1'b0;
    else if (cs_q)   held_q <= 1'b0;
    else if (!sck_s) held_q <= ~hold_s;
  end

  logic active;
  assign active = ~cs_q & ~held_q & ~locked_q;

  logic             rx_take, tx_step, byte_done, first_byte, op_legal;
  logic [BIT_W-1:0] bit_cnt_q;
  logic [IDX_W-1:0] byte_cnt_q;
  byte_t            rx_sh_q, rx_word;

  assign rx_take    = sck_rise & active;
  assign tx_step    = sck_fall & active;
  assign byte_done  = rx_take & (bit_cnt_q == LAST_BIT);
  assign first_byte = (byte_cnt_q == '0);
  assign rx_word    = {rx_sh_q[BYTE_W-2:0], si_s};

  spi_fe_opcheck #(
    .NUM  (NUM_LEGAL),
    .CODES(LEGAL_CODES)
  ) u_opcheck (
    .code_i (rx_word),
    .legal_o(op_legal)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      rx_sh_q    <= '0;
      locked_q   <= 1'b0;
    end else if (cs_fall) begin
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      locked_q   <= 1'b0;
    end else if (rx_take) begin
      rx_sh_q   <= rx_word;
      bit_cnt_q <= bit_cnt_q + 1'b1;
      if (byte_done) begin
        if (byte_cnt_q != '1) byte_cnt_q <= byte_cnt_q + 1'b1;
        if (first_byte && !op_legal) locked_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_valid_o     <= 1'b0;
      rx_byte_o      <= '0;
      rx_idx_o       <= '0;
      opcode_valid_o <= 1'b0;
      opcode_o       <= '0;
      opcode_legal_o <= 1'b0;
    end else begin
      rx_valid_o     <= byte_done;
      opcode_valid_o <= byte_done & first_byte;
      if (byte_done) begin
        rx_byte_o <= rx_word;
        rx_idx_o  <= byte_cnt_q;
        if (first_byte) begin
          opcode_o       <= rx_word;
          opcode_legal_o <= op_legal;
        end
      end
    end
  end

  // reply byte enters at the falling edge that closes each byte
  logic tx_load;
  assign tx_load = tx_step & (bit_cnt_q == '0) & ~first_byte;

  spi_fe_txshift u_txshift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cs_fall),
    .load_i (tx_load),
    .shift_i(tx_step),
    .din_i  (tx_byte_i),
    .msb_o  (so_o)
  );

  assign so_oe_o = active;
endmodule

// File: rtl/spi_fe_checker.sv
module spi_fe_checker
  import spi_fe_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_valid_o,
  input logic             opcode_valid_o,
  input logic             opcode_legal_o,
  input logic             so_oe_o,
  input logic             locked_q,
  input logic             held_q,
  input logic             cs_q,
  input logic [BIT_W-1:0] bit_cnt_q
);
  // R6
  a_r6_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  // R2
  a_r2_opcode_with_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opcode_valid_o |-> rx_valid_o);
  // R3
  a_r3_lock_on_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_valid_o && !opcode_legal_o) |-> (locked_q && !so_oe_o));
  // R3
  a_r3_locked_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> !rx_valid_o);
  // R5
  a_r5_hold_freezes_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_q |=> $stable(bit_cnt_q));
  // R4
  a_r4_deselected_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q |=> !rx_valid_o);
endmodule

bind spi_hold_frontend spi_fe_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rx_valid_o    (rx_valid_o),
  .opcode_valid_o(opcode_valid_o),
  .opcode_legal_o(opcode_legal_o),
  .so_oe_o       (so_oe_o),
  .locked_q      (locked_q),
  .held_q        (held_q),
  .cs_q          (cs_q),
  .bit_cnt_q     (bit_cnt_q)
);

// File: tb/spi_hold_frontend_tb_top.sv
`timescale 1ns/1ps
module spi_hold_frontend_tb_top;
  localparam int NL    = 3;
  localparam int IDXW  = 4;
  localparam int HALF  = 10;
  localparam logic [NL*8-1:0] CODES = {8'h9F, 8'h0B, 8'h03};

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic [7:0] tx_byte = '0;
  logic so, so_oe, op_valid, op_legal, rx_valid;
  logic [7:0] opcode, rx_byte;
  logic [IDXW-1:0] rx_idx;

  always #2.5 clk = ~clk;

  spi_hold_frontend #(
    .SYNC_STAGES(3), .IDX_W(IDXW), .NUM_LEGAL(NL), .LEGAL_CODES(CODES)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .hold_ni(hold_n), .so_o(so), .so_oe_o(so_oe), .opcode_o(opcode),
    .opcode_valid_o(op_valid), .opcode_legal_o(op_legal), .rx_byte_o(rx_byte),
    .rx_valid_o(rx_valid), .rx_idx_o(rx_idx), .tx_byte_i(tx_byte)
  );

  int n_checks = 0, n_fail = 0;
  logic [7:0] rx_got[$];
  int         idx_got[$];
  int         op_cnt = 0;
  logic [7:0] op_seen;
  logic       legal_seen;
  logic [7:0] mosi[8];
  logic [7:0] resp[9];

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        rx_got.push_back(rx_byte);
        idx_got.push_back(int'(rx_idx));
      end
      if (op_valid) begin
        op_cnt++;
        op_seen    = opcode;
        legal_seen = op_legal;
      end
    end
  end

  function automatic bit is_legal(input logic [7:0] c);
    for (int k = 0; k < NL; k++) if (CODES[k*8 +: 8] == c) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  // pause with the serial clock low, wiggle pins, then resume
  task automatic do_hold();
    hold_n = 1'b0;
    wait_half();
    check(so_oe == 1'b0, "R5 hold oe", int'(so_oe), 0);
    for (int t = 0; t < 3; t++) begin
      si = 1'($urandom);
      sck = 1'b1; wait_half();
      sck = 1'b0; wait_half();
    end
    check(so_oe == 1'b0, "R5 hold oe after sck", int'(so_oe), 0);
    hold_n = 1'b1;
    wait_half();
  endtask

  task automatic run_xfer(input int nb, input int hold_bit);
    bit legal;
    int so_err = 0, oe_err = 0, n_exp;
    legal = is_legal(mosi[0]);
    resp[0] = 8'h00;
    rx_got.delete(); idx_got.delete(); op_cnt = 0;
    cs_n = 1'b0;
    wait_half();
    for (int b = 0; b < nb; b++) begin
      for (int i = 7; i >= 0; i--) begin
        bit exp_oe;
        if (hold_bit == b*8 + (7-i)) do_hold();
        if (i == 3) tx_byte = resp[b+1];
        si = mosi[b][i];
        wait_half();
        exp_oe = (b == 0) || legal;
        if (so_oe !== exp_oe) oe_err++;
        else if (exp_oe && so !== resp[b][i]) so_err++;
        sck = 1'b1; wait_half();
        sck = 1'b0;
      end
    end
    wait_half();
    cs_n = 1'b1;
    wait_half(); wait_half();
    n_exp = legal ? nb : 1;
    check(op_cnt == 1, "R2 one opcode strobe", op_cnt, 1);
    check(op_seen == mosi[0], "R2 opcode value", int'(op_seen), int'(mosi[0]));
    check(legal_seen == legal, "R2 legal flag", int'(legal_seen), int'(legal));
    check(rx_got.size() == n_exp, legal ? "R6 byte count" : "R3 no bytes after illegal",
          rx_got.size(), n_exp);
    for (int k = 0; k < rx_got.size() && k < n_exp; k++) begin
      check(rx_got[k] == mosi[k], "R1 rx byte msb first", int'(rx_got[k]), int'(mosi[k]));
      check(idx_got[k] == k, "R6 byte index", idx_got[k], k);
    end
    check(so_err == 0, "R7 reply bits on so", so_err, 0);
    check(oe_err == 0, legal ? "R7 oe while selected" : "R3 oe low after illegal", oe_err, 0);
  endtask

  task automatic partial(input int nbits);
    cs_n = 1'b0; wait_half();
    for (int i = 0; i < nbits; i++) begin
      si = 1'b1; wait_half();
      sck = 1'b1; wait_half();
      sck = 1'b0;
    end
    wait_half();
    cs_n = 1'b1; wait_half();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (5) @(negedge clk);
    check(so_oe == 1'b0, "R4 reset oe", int'(so_oe), 0);
    check(rx_valid == 1'b0 && op_valid == 1'b0, "R6 reset strobes", int'(rx_valid), 0);
    rst_n = 1'b1;
    wait_half();

    // R4: clocks while deselected
    rx_got.delete(); op_cnt = 0;
    for (int t = 0; t < 16; t++) begin
      si = 1'($urandom);
      sck = 1'b1; wait_half();
      sck = 1'b0; wait_half();
      if (so_oe !== 1'b0) check(1'b0, "R4 oe while deselected", int'(so_oe), 0);
    end
    check(rx_got.size() == 0 && op_cnt == 0, "R4 no strobe while deselected",
          rx_got.size(), 0);

    // R1 R2 R6 R7: plain legal transfer
    mosi[0] = 8'h03; mosi[1] = 8'hA5; mosi[2] = 8'h5A; mosi[3] = 8'h81;
    resp[1] = 8'hC3; resp[2] = 8'h3C; resp[3] = 8'h7E; resp[4] = 8'h00;
    run_xfer(4, -1);

    // R5: pause inside byte 2 and inside the command byte
    mosi[0] = 8'h9F; mosi[1] = 8'h12; mosi[2] = 8'hF0; mosi[3] = 8'h0F;
    resp[1] = 8'h96; resp[2] = 8'h69; resp[3] = 8'hE1; resp[4] = 8'h1E;
    run_xfer(4, 19);
    run_xfer(3, 4);
    run_xfer(3, 8);

    // R3: unlisted command locks the rest
    mosi[0] = 8'hFF; mosi[1] = 8'h11; mosi[2] = 8'h22; mosi[3] = 8'h33;
    run_xfer(4, -1);

    // R8: new select clears lock and index
    mosi[0] = 8'h0B; mosi[1] = 8'h44; mosi[2] = 8'hBE;
    resp[1] = 8'hAA; resp[2] = 8'h55; resp[3] = 8'h00;
    run_xfer(3, -1);
    check(idx_got.size() > 0 && idx_got[0] == 0, "R8 index restart after lock",
          idx_got.size() > 0 ? idx_got[0] : -1, 0);

    // R8: aborted mid-byte transfer leaves no residue
    partial(3);
    mosi[0] = 8'h03; mosi[1] = 8'h6D;
    resp[1] = 8'hB2; resp[2] = 8'h00;
    run_xfer(2, -1);

    // random mix
    for (int r = 0; r < 20; r++) begin
      int nb, hb;
      nb = 1 + int'($urandom % 5);
      if ($urandom % 4 == 0) mosi[0] = 8'($urandom);
      else mosi[0] = CODES[($urandom % NL)*8 +: 8];
      for (int k = 1; k < 8; k++) mosi[k] = 8'($urandom);
      for (int k = 1; k < 9; k++) resp[k] = 8'($urandom);
      hb = ($urandom % 2 == 0) ? int'($urandom % (nb*8)) : -1;
      run_xfer(nb, hb);
    end

    summary();
  end
endmodule